// File: doc/BRIEF.md
# Serial Flash Command Register Front End

This block is the software-facing half of a serial flash controller. It is an APB slave that holds everything needed to describe one flash command: an opcode, which phases the command has (address, read data, write data), how many dummy clocks follow the address, a byte count, a 24-bit flash address and up to four 32-bit words of outgoing data. A control register selects quad or single I/O for the data phase. It also carries a continuous-read mode byte and the flag that enables it. These values drive a separate shift engine as static fields, and the engine runs on its own serial clock.

Software launches a command by writing the command word twice. The first write has the start bit clear. The second write carries the same word with only the start bit inverted. The change of that bit, not its value, is the request. The request reaches the serial-clock domain through a toggle synchronizer and appears there as a single-cycle start pulse. An activity flag in the serial domain covers the interval from the start pulse to the engine's busy falling edge. That flag returns through a two-flop synchronizer and, together with a local pending bit, forms the busy bit in the status register. In the serial domain, received data beats are packed most-significant first into a 128-bit capture register, which is cleared by every start. Software reads that register as four words once busy has dropped.

Top module: `qf_cmd_frontend`

## Requirements
- R1: After reset every register reads as zero, status bit 0 is 0, and no start pulse is issued.
- R2: The command word at 0x08 stores bits [19:0] and drives the engine: opcode [7:0], start bit 8, read enable 9, write enable 10, address enable 11, dummy count [15:12], byte count minus one [19:16]. The address at 0x0C keeps 24 bits. Write words at 0x20, 0x24, 0x28 and 0x2C read back and drive the outgoing data, with the word at 0x20 in the top 32 bits.
- R3: A write to 0x08 that changes bit 8 while idle produces exactly one start pulse, one serial clock wide. A write that leaves bit 8 unchanged produces none.
- R4: Status bit 0 at 0x04 reads 1 from the cycle after a launching write. It stays 1 until the engine's busy input has fallen and that fall has crossed back. It then reads 0.
- R5: While status bit 0 is 1, writes to 0x08, 0x0C and 0x20 to 0x2C have no effect, and a toggle of bit 8 launches nothing.
- R6: The capture register is cleared by every start pulse, so words not reached by the current transfer read as zero.
- R7: In quad mode (control bit 0 = 1) each data beat stores all four lines. Beat k goes to capture bits [127-4k : 124-4k], so the first beat lands in bits [31:28] of the word at 0x10. The words at 0x10, 0x14, 0x18 and 0x1C hold capture bits [127:96], [95:64], [63:32] and [31:0].
- R8: In single mode (control bit 0 = 0) each beat stores only line 1 (nibble bit 1), and beat k lands at capture bit 127-k.
- R9: Beats that arrive after all 128 capture bits are filled are ignored.
- R10: Reads of unmapped or misaligned addresses return zero. Writes to status or to unmapped addresses change nothing.
- R11: The control register at 0x00 holds the quad flag in bit 0, the continuous-read mode byte in bits [23:16] and the continuous-read enable in bit 24. It can be written at any time and drives the matching engine outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| prst | input | 1 | Synchronous active-high reset, APB domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, registered in the setup phase |
| sclk | input | 1 | Serial engine clock |
| srst | input | 1 | Synchronous active-high reset, serial domain |
| eng_start | output | 1 | One-cycle start pulse, serial domain |
| eng_busy | input | 1 | Engine busy, serial domain |
| eng_rx_valid | input | 1 | Received data beat valid |
| eng_rx_nib | input | 4 | Received I/O line values for one beat |
| eng_opcode | output | 8 | Flash opcode |
| eng_rd_en | output | 1 | Read phase enable |
| eng_wr_en | output | 1 | Write phase enable |
| eng_addr_en | output | 1 | Address phase enable |
| eng_dummy | output | 4 | Dummy clock count |
| eng_nbytes | output | 4 | Data byte count minus one |
| eng_addr | output | FADDR_W | Flash address |
| eng_wdata | output | NWORDS*DATA_W | Outgoing data, first word in the top bits |
| eng_quad | output | 1 | Quad I/O data phase |
| eng_cont_rd | output | 1 | Continuous-read enable |
| eng_mode_byte | output | 8 | Continuous-read mode byte |

## Verification
The bound checker watches, on every cycle, the properties that hold locally in time. The start pulse is one serial clock wide. A launching write sets busy on the next APB cycle. Field outputs stay frozen across writes made while busy. The capture register reads zero right after a start. Unmapped reads and reset produce zero data. Other behaviours depend on a full transfer crossing both clock domains, and only the bench scenarios can show them. These are the single launch per toggle, busy falling after the engine finishes, quad versus single packing, truncation after 128 bits, and the clearing of words from an earlier transfer. The bench drives these with a behavioural engine that feeds seeded random beats, and it compares the four read words with a packing model.

// File: rtl/qf_pkg.sv
package qf_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_STAT  = 'h04;
  localparam int unsigned OFS_CMD   = 'h08;
  localparam int unsigned OFS_FADDR = 'h0C;
  localparam int unsigned OFS_RD    = 'h10;
  localparam int unsigned OFS_WR    = 'h20;

  // packed MSB first: bit 19 down to bit 0 of the command word
  typedef struct packed {
    logic [3:0] nbytes_m1;
    logic [3:0] dummy;
    logic       addr_en;
    logic       wr_en;
    logic       rd_en;
    logic       start;
    logic [7:0] opcode;
  } cmd_t;

  localparam int unsigned CMD_W = $bits(cmd_t);
endpackage

// File: rtl/qf_sync2.sv
module qf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qf_toggle_sync.sv
module qf_toggle_sync (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      pulse <= 1'b0;
    end else begin
      sh    <= {sh[1:0], tgl_in};
      pulse <= sh[1] ^ sh[2];
    end
  end
endmodule

// File: rtl/qf_rx_capture.sv
module qf_rx_capture #(
  parameter int CAP_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             eng_busy,
  input  logic             rx_valid,
  input  logic [3:0]       rx_nib,
  input  logic             quad,
  output logic [CAP_W-1:0] cap,
  output logic             active
);
  localparam int PTR_W = $clog2(CAP_W) + 1;

  logic [PTR_W-1:0] ptr;
  logic             busy_q;
  int               hi_idx;

  always_comb hi_idx = CAP_W - 1 - int'(ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= eng_busy;
      if (start)
        active <= 1'b1;
      else if (busy_q && !eng_busy)
        active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cap <= '0;
      ptr <= '0;
    end else if (rx_valid) begin
      if (quad) begin
        if (int'(ptr) <= CAP_W - 4) begin
          cap[hi_idx -: 4] <= rx_nib;
          ptr <= ptr + PTR_W'(4);
        end
      end else begin
        if (int'(ptr) < CAP_W) begin
          cap[hi_idx] <= rx_nib[1];
          ptr <= ptr + PTR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qf_apb_regs.sv
module qf_apb_regs
  import qf_pkg::*;
#(
  parameter int PADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int NWORDS  = 4,
  parameter int FADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [PADDR_W-1:0]       paddr,
  input  logic [DATA_W-1:0]        pwdata,
  output logic [DATA_W-1:0]        prdata,
  input  logic                     act_sync,
  input  logic [NWORDS*DATA_W-1:0] cap,
  output cmd_t                     cmd_q,
  output logic [FADDR_W-1:0]       faddr_q,
  output logic [NWORDS*DATA_W-1:0] wdata_flat,
  output logic                     quad_q,
  output logic                     cont_q,
  output logic [7:0]               mode_q,
  output logic                     busy
);
  localparam int CAP_W = NWORDS * DATA_W;

  logic [DATA_W-1:0] wd [NWORDS];
  logic              pending;
  logic              act_q;
  logic              wr_acc;
  logic              rd_setup;
  logic [DATA_W-1:0] rd_val;

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign busy     = pending || act_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      faddr_q <= '0;
      quad_q  <= 1'b0;
      cont_q  <= 1'b0;
      mode_q  <= '0;
      pending <= 1'b0;
      act_q   <= 1'b0;
      for (int i = 0; i < NWORDS; i++) wd[i] <= '0;
    end else begin
      act_q <= act_sync;
      if (act_sync && !act_q) pending <= 1'b0;
      if (wr_acc) begin
        if (paddr == PADDR_W'(OFS_CTRL)) begin
          quad_q <= pwdata[0];
          mode_q <= pwdata[23:16];
          cont_q <= pwdata[24];
        end
        if (!busy) begin
          if (paddr == PADDR_W'(OFS_CMD)) begin
            cmd_q <= cmd_t'(pwdata[CMD_W-1:0]);
            if (pwdata[8] != cmd_q.start) pending <= 1'b1;
          end
          if (paddr == PADDR_W'(OFS_FADDR)) faddr_q <= pwdata[FADDR_W-1:0];
          for (int i = 0; i < NWORDS; i++)
            if (paddr == PADDR_W'(OFS_WR + 4 * i)) wd[i] <= pwdata;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (paddr == PADDR_W'(OFS_CTRL))
      rd_val = DATA_W'({7'd0, cont_q, mode_q, 15'd0, quad_q});
    if (paddr == PADDR_W'(OFS_STAT))  rd_val = DATA_W'(busy);
    if (paddr == PADDR_W'(OFS_CMD))   rd_val = DATA_W'(cmd_q);
    if (paddr == PADDR_W'(OFS_FADDR)) rd_val = DATA_W'(faddr_q);
    for (int i = 0; i < NWORDS; i++) begin
      if (paddr == PADDR_W'(OFS_RD + 4 * i)) rd_val = cap[CAP_W-1-i*DATA_W -: DATA_W];
      if (paddr == PADDR_W'(OFS_WR + 4 * i)) rd_val = wd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_val;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_wflat
    assign wdata_flat[CAP_W-1-g*DATA_W -: DATA_W] = wd[g];
  end
endmodule

// File: rtl/qf_cmd_frontend.sv
module qf_cmd_frontend
  import qf_pkg::*;
#(
  parameter int PADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int NWORDS  = 4,
  parameter int FADDR_W = 24
) (
  input  logic                     pclk,
  input  logic                     prst,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [PADDR_W-1:0]       paddr,
  input  logic [DATA_W-1:0]        pwdata,
  output logic [DATA_W-1:0]        prdata,
  input  logic                     sclk,
  input  logic                     srst,
  output logic                     eng_start,
  input  logic                     eng_busy,
  input  logic                     eng_rx_valid,
  input  logic [3:0]               eng_rx_nib,
  output logic [7:0]               eng_opcode,
  output logic                     eng_rd_en,
  output logic                     eng_wr_en,
  output logic                     eng_addr_en,
  output logic [3:0]               eng_dummy,
  output logic [3:0]               eng_nbytes,
  output logic [FADDR_W-1:0]       eng_addr,
  output logic [NWORDS*DATA_W-1:0] eng_wdata,
  output logic                     eng_quad,
  output logic                     eng_cont_rd,
  output logic [7:0]               eng_mode_byte
);
  localparam int CAP_W = NWORDS * DATA_W;

  cmd_t             cmd_q;
  logic             st_busy;
  logic             act_s;
  logic             act_p;
  logic [CAP_W-1:0] cap_w;

  qf_apb_regs #(
    .PADDR_W(PADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS), .FADDR_W(FADDR_W)
  ) u_regs (
    .clk(pclk), .rst(prst),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .act_sync(act_p), .cap(cap_w),
    .cmd_q(cmd_q), .faddr_q(eng_addr), .wdata_flat(eng_wdata),
    .quad_q(eng_quad), .cont_q(eng_cont_rd), .mode_q(eng_mode_byte),
    .busy(st_busy)
  );

  qf_toggle_sync u_start_x (
    .clk(sclk), .rst(srst), .tgl_in(cmd_q.start), .pulse(eng_start)
  );

  qf_rx_capture #(.CAP_W(CAP_W)) u_cap (
    .clk(sclk), .rst(srst), .start(eng_start), .eng_busy(eng_busy),
    .rx_valid(eng_rx_valid), .rx_nib(eng_rx_nib), .quad(eng_quad),
    .cap(cap_w), .active(act_s)
  );

  qf_sync2 #(.W(1)) u_busy_x (
    .clk(pclk), .rst(prst), .d(act_s), .q(act_p)
  );

  assign eng_opcode  = cmd_q.opcode;
  assign eng_rd_en   = cmd_q.rd_en;
  assign eng_wr_en   = cmd_q.wr_en;
  assign eng_addr_en = cmd_q.addr_en;
  assign eng_dummy   = cmd_q.dummy;
  assign eng_nbytes  = cmd_q.nbytes_m1;
endmodule

// File: rtl/qf_cmd_frontend_chk.sv
module qf_cmd_frontend_chk #(
  parameter int PADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int NWORDS  = 4,
  parameter int FADDR_W = 24
) (
  input logic                     pclk,
  input logic                     prst,
  input logic                     sclk,
  input logic                     srst,
  input logic                     psel,
  input logic                     penable,
  input logic                     pwrite,
  input logic [PADDR_W-1:0]       paddr,
  input logic [DATA_W-1:0]        pwdata,
  input logic [DATA_W-1:0]        prdata,
  input logic                     eng_start,
  input logic                     eng_rx_valid,
  input logic [7:0]               eng_opcode,
  input logic [3:0]               eng_nbytes,
  input logic [FADDR_W-1:0]       eng_addr,
  input logic                     st_busy,
  input logic                     start_bit,
  input logic [NWORDS*DATA_W-1:0] cap
);
  localparam int unsigned MAP_END = 'h20 + 4 * NWORDS;

  logic wr_acc;
  assign wr_acc = psel && penable && pwrite;

  // R1
  reset_zero_chk: assert property (@(posedge pclk)
    prst |=> (prdata == '0 && !st_busy));

  // R3
  start_pulse_chk: assert property (@(posedge sclk) disable iff (srst)
    eng_start |=> !eng_start);

  // R4
  launch_busy_chk: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && paddr == PADDR_W'('h08) && !st_busy && pwdata[8] != start_bit) |=> st_busy);

  // R5
  busy_hold_chk: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && st_busy) |=> ($stable(eng_addr) && $stable(eng_opcode) && $stable(eng_nbytes)));

  // R6
  cap_clear_chk: assert property (@(posedge sclk) disable iff (srst)
    (eng_start && !eng_rx_valid) |=> (cap == '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (prst)
    (psel && !penable && !pwrite && (paddr[1:0] != 2'b00 || int'(paddr) >= int'(MAP_END)))
      |=> (prdata == '0));
endmodule

bind qf_cmd_frontend qf_cmd_frontend_chk #(
  .PADDR_W(PADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS), .FADDR_W(FADDR_W)
) u_chk (
  .pclk(pclk), .prst(prst), .sclk(sclk), .srst(srst),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .pwdata(pwdata), .prdata(prdata), .eng_start(eng_start),
  .eng_rx_valid(eng_rx_valid), .eng_opcode(eng_opcode),
  .eng_nbytes(eng_nbytes), .eng_addr(eng_addr), .st_busy(st_busy),
  .start_bit(cmd_q.start), .cap(cap_w)
);

// File: tb/qf_cmd_frontend_tb.sv
module qf_cmd_frontend_tb;
  logic         pclk = 0, sclk = 0, prst = 1, srst = 1;
  logic         psel = 0, penable = 0, pwrite = 0;
  logic [7:0]   paddr = 0;
  logic [31:0]  pwdata = 0, prdata;
  logic         eng_start, eng_busy = 0, eng_rx_valid = 0;
  logic [3:0]   eng_rx_nib = 0;
  logic [7:0]   eng_opcode, eng_mode_byte;
  logic         eng_rd_en, eng_wr_en, eng_addr_en, eng_quad, eng_cont_rd;
  logic [3:0]   eng_dummy, eng_nbytes;
  logic [23:0]  eng_addr;
  logic [127:0] eng_wdata;

  int checks = 0, errors = 0, start_cnt = 0;
  int m_beats = 0, m_seed = 0;
  logic cur_start = 0;
  bit done = 0;

  always #5 pclk = ~pclk;
  always #8 sclk = ~sclk;

  qf_cmd_frontend u_dut (
    .pclk(pclk), .prst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sclk(sclk), .srst(srst),
    .eng_start(eng_start), .eng_busy(eng_busy), .eng_rx_valid(eng_rx_valid),
    .eng_rx_nib(eng_rx_nib), .eng_opcode(eng_opcode), .eng_rd_en(eng_rd_en),
    .eng_wr_en(eng_wr_en), .eng_addr_en(eng_addr_en), .eng_dummy(eng_dummy),
    .eng_nbytes(eng_nbytes), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_quad(eng_quad), .eng_cont_rd(eng_cont_rd), .eng_mode_byte(eng_mode_byte)
  );

  function automatic logic [3:0] nib_of(int seed, int k);
    return 4'((seed * 7 + k * 3 + (k >> 2)) ^ (seed >> 4));
  endfunction

  function automatic logic [127:0] exp_cap(bit quad, int seed, int beats);
    logic [127:0] c = '0;
    for (int k = 0; k < beats; k++) begin
      if (quad) begin
        if (k < 32) c[127 - 4 * k -: 4] = nib_of(seed, k);
      end else if (k < 128) c[127 - k] = nib_of(seed, k)[1];
    end
    return c;
  endfunction

  // behavioural shift engine, serial domain
  initial begin
    int k = 0;
    bit run = 0;
    forever begin
      @(negedge sclk);
      if (!srst) begin
        if (eng_start) start_cnt++;
        if (!run) begin
          if (eng_start) begin run = 1; k = 0; eng_busy = 1; end
        end else if (k < m_beats) begin
          eng_rx_valid = 1; eng_rx_nib = nib_of(m_seed, k); k++;
        end else begin
          eng_rx_valid = 0; eng_busy = 0; run = 0;
        end
      end
    end
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(logic [7:0] a, logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin apb_rd(8'h04, s); n++; end while (s[0] && n < 3000);
    check("R4 busy clears", 128'(s[0]), 128'(0));
  endtask

  task automatic launch(logic [19:0] cmd);
    apb_wr(8'h08, {12'd0, cmd[19:9], cur_start, cmd[7:0]});
    cur_start = ~cur_start;
    apb_wr(8'h08, {12'd0, cmd[19:9], cur_start, cmd[7:0]});
  endtask

  task automatic read_cap(output logic [127:0] c);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      apb_rd(8'(8'h10 + 4 * i), w);
      c[127 - 32 * i -: 32] = w;
    end
  endtask

  task automatic xfer(bit quad, int seed, int beats, string req);
    logic [31:0] s;
    logic [127:0] c;
    int s0;
    apb_wr(8'h00, {7'd0, 1'b0, 8'h00, 15'd0, quad});
    m_seed = seed; m_beats = beats; s0 = start_cnt;
    launch({4'hF, 4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0B});
    apb_rd(8'h04, s);
    check("R4 busy after launch", 128'(s[0]), 128'(1));
    wait_idle();
    check("R3 one start per toggle", 128'(start_cnt - s0), 128'(1));
    read_cap(c);
    check(req, c, exp_cap(quad, seed, beats));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    logic [127:0] c;
    int s0;
    void'($urandom(1234));
    repeat (10) @(posedge pclk);
    @(negedge pclk); prst = 0; srst = 0;
    repeat (5) @(negedge pclk);

    // R1 reset state
    for (int a = 0; a < 'h30; a += 4) begin
      apb_rd(8'(a), d);
      check("R1 reset reads zero", 128'(d), 128'(0));
    end
    check("R1 no start after reset", 128'(start_cnt), 128'(0));

    // R2 readback and engine fields
    v = $urandom;
    apb_wr(8'h0C, v);
    apb_rd(8'h0C, d);
    check("R2 address readback", 128'(d), 128'(v[23:0]));
    check("R2 address output", 128'(eng_addr), 128'(v[23:0]));
    for (int i = 0; i < 4; i++) begin
      v = $urandom;
      apb_wr(8'(8'h20 + 4 * i), v);
      apb_rd(8'(8'h20 + 4 * i), d);
      check("R2 write word readback", 128'(d), 128'(v));
      check("R2 write word output", 128'(eng_wdata[127 - 32 * i -: 32]), 128'(v));
    end
    s0 = start_cnt;
    apb_wr(8'h08, 32'hFFF5_E6A5);   // start bit 0, unchanged
    apb_rd(8'h08, d);
    check("R2 command readback", 128'(d), 128'(20'h5E6A5 & 20'hFFEFF));
    check("R2 opcode", 128'(eng_opcode), 128'(8'hA5));
    check("R2 phase enables", 128'({eng_addr_en, eng_wr_en, eng_rd_en}), 128'(3'b011));
    check("R2 dummy and count", 128'({eng_nbytes, eng_dummy}), 128'(8'h5E));
    repeat (20) @(negedge pclk);
    check("R3 no start without toggle", 128'(start_cnt - s0), 128'(0));

    // R11 control
    apb_wr(8'h00, 32'hFF5A_FFFF);
    apb_rd(8'h00, d);
    check("R11 control readback", 128'(d), 128'(32'h015A_0001));
    check("R11 control outputs", 128'({eng_cont_rd, eng_mode_byte, eng_quad}), 128'({1'b1, 8'h5A, 1'b1}));

    // R10 unmapped and status writes
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_wr(8'h30, 32'h1234_5678);
    apb_rd(8'h04, d); check("R10 status write ignored", 128'(d), 128'(0));
    apb_rd(8'h30, d); check("R10 unmapped read", 128'(d), 128'(0));
    apb_rd(8'h0E, d); check("R10 misaligned read", 128'(d), 128'(0));
    apb_rd(8'hFC, d); check("R10 high read", 128'(d), 128'(0));

    // R7 quad full, R8 single short, R6 clearing
    xfer(1, 17, 32, "R7 quad capture 16 bytes");
    xfer(0, 99, 32, "R8 single capture, R6 rest cleared");
    xfer(1, 5, 3, "R7 quad first nibble top, R6 cleared");

    // R5 and R9: long single transfer, writes while busy
    apb_wr(8'h00, 32'h0);
    apb_wr(8'h0C, 32'h00AB_CDEF);
    apb_wr(8'h20, 32'h1111_2222);
    m_seed = 42; m_beats = 200; s0 = start_cnt;
    launch({4'h3, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03});
    apb_wr(8'h0C, 32'h0012_3456);
    apb_wr(8'h20, 32'hDEAD_BEEF);
    apb_wr(8'h08, {12'd0, 4'h7, 4'd2, 3'b101, ~cur_start, 8'h77});
    apb_rd(8'h04, d); check("R5 still busy", 128'(d[0]), 128'(1));
    wait_idle();
    apb_rd(8'h0C, d); check("R5 address held", 128'(d), 128'(24'hABCDEF));
    apb_rd(8'h20, d); check("R5 write word held", 128'(d), 128'(32'h1111_2222));
    apb_rd(8'h08, d);
    check("R5 command held", 128'(d), 128'({4'h3, 4'd0, 1'b1, 1'b0, 1'b1, cur_start, 8'h03}));
    check("R5 no launch while busy", 128'(start_cnt - s0), 128'(1));
    read_cap(c);
    check("R9 extra beats ignored", c, exp_cap(0, 42, 200));
    xfer(1, 77, 45, "R9 quad overflow ignored");

    // random transfers
    for (int t = 0; t < 16; t++) begin
      bit q = 1'($urandom);
      int sd = int'($urandom % 1000);
      int bt = 1 + int'($urandom % 40);
      xfer(q, sd, bt, q ? "R7 random quad" : "R8 random single");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule